// File: doc/BRIEF.md
# Power and Sleep Controller

This block holds the power state of a small group of power domains and of the clock-gated modules placed inside them. Software reaches it through a plain 32-bit register port with byte addresses on word boundaries. Each module has a request register and a state register. Each domain has a request register and a state register. Three global registers start work, show busy domains and flag domains that are waiting for outside power.

Software writes the wanted state of one or more modules, then issues a per-domain go command. That domain's modules take the new state after a fixed step delay. A module that is running does not leave the enabled state until it signals idle, unless its force bit is set.

An unpowered domain first raises a power request and a pending flag. It waits until an external acknowledge arrives and software confirms that power is good. Only then do its modules move. Each module drives a clock-enable output and an active-low local reset output.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset, domain 0 is powered and every other domain is off. Every module reads state 0 and its clock enable is low. Every local reset output is low. The busy register (0x128) and the pending register (0x070) read 0. Each module request register reads 0x100.
- R2: Module request register 0xA00+4m has these fields. Bits [1:0] hold the wanted state: 0 = off with reset, 1 = synchronous reset, 2 = clock gated, 3 = enabled. Bits [5:2] always read 0. Bit 8 is the local reset release (active low, 1 after reset). Bit 31 is the force bit. Writes read back with only these bits kept.
- R3: Writing 1 to bit d of 0x120 for a powered, idle domain d does three things. It captures the wanted states of that domain's modules. It sets bit d of 0x128. After STEP_CYC clock edges, the module states and the busy bit change on the same edge.
- R4: Module state register 0x800+4m shows the current state in bits [5:0]. Bit 12 and the clock-enable output are 1 only in state 3.
- R5: The local reset output of a module is high only when its request bit 8 is 1 and its state is 2 or 3.
- R6: A module in state 3 that is asked for another state moves only in a step where its idle input is high or its force bit is set. Until then, the domain stays busy.
- R7: A go for a domain that is busy is ignored. In particular, the wanted states captured at the accepted go stay in force.
- R8: A go for an unpowered domain whose request bit 0 (0x300+4d) is set does two things. It sets bit d of 0x070 and raises the power request output. The domain powers up only when request bit 8 (power good) is 1 and the acknowledge input is high. At that point the pending bit clears and the modules step.
- R9: A go for an unpowered domain whose request bit 0 is 0 is ignored. The domain stays idle and its modules keep their state.
- R10: A go affects only the modules that the MOD_DOM parameter assigns to that domain (four bits per module).
- R11: Domain state register 0x200+4d reads 1 when the domain is powered and 0 when it is off. A powered domain stays powered. The domain request register reads back bits 0 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wen | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mod_idle | input | NUM_MOD | Module may leave the enabled state |
| mod_clk_en | output | NUM_MOD | Module clock enable |
| mod_rst_n | output | NUM_MOD | Module local reset, active low |
| pwr_ack | input | NUM_DOM | External power switch acknowledge |
| pwr_req | output | NUM_DOM | Power-up request to the external switch |

## Verification
The bench samples the busy bit and the module state on each of the STEP_CYC edges after a go. A design whose step timing is off by one would show the new state early or drop busy one cycle late.

It holds a running module in place with idle low and then changes its request register. It then reissues go while the domain is busy. A design that re-captured the request would end in the wrong state, and one that did not wait for idle would drop busy too soon.

An unpowered domain is given power good without an acknowledge, and a go is sent to a domain with no power-up request. A design that skipped either part of the handshake, or that moved modules in an off domain, would show the wrong domain state, pending bit or module state.

// File: rtl/psc_pkg.sv
`timescale 1ns/1ps
package psc_pkg;
  typedef enum logic [1:0] {
    MS_OFF   = 2'd0,
    MS_SRST  = 2'd1,
    MS_GATED = 2'd2,
    MS_ON    = 2'd3
  } mstate_e;

  typedef enum logic [1:0] {
    DS_IDLE = 2'd0,
    DS_PEND = 2'd1,
    DS_STEP = 2'd2
  } dstate_e;

  localparam logic [11:0] A_PEND  = 12'h070;
  localparam logic [11:0] A_GO    = 12'h120;
  localparam logic [11:0] A_BUSY  = 12'h128;
  localparam logic [11:0] A_DSTAT = 12'h200;
  localparam logic [11:0] A_DCTL  = 12'h300;
  localparam logic [11:0] A_MSTAT = 12'h800;
  localparam logic [11:0] A_MCTL  = 12'hA00;

  localparam int B_LRST  = 8;
  localparam int B_FORCE = 31;
  localparam int B_GOOD  = 8;
  localparam int B_ONREQ = 0;
endpackage

// File: rtl/psc_module_unit.sv
`timescale 1ns/1ps
module psc_module_unit
  import psc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [1:0]  nxt_in,
  input  logic        lrst_in,
  input  logic        force_in,
  input  logic        latch,
  input  logic        apply,
  input  logic        idle_ok,
  output logic [31:0] ctl_q,
  output logic [31:0] stat_q,
  output mstate_e     cur_q,
  output logic        ok_next,
  output logic        clk_en,
  output logic        rst_out_n
);
  mstate_e nxt_q;
  mstate_e tgt_q;
  logic    lrst_q;
  logic    force_q;
  logic    leave_ok;

  // a running module may only leave when idle or forced
  assign leave_ok = (cur_q != MS_ON) || idle_ok || force_q;
  assign ok_next  = (cur_q == tgt_q) || leave_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_q   <= MS_OFF;
      tgt_q   <= MS_OFF;
      cur_q   <= MS_OFF;
      lrst_q  <= 1'b1;
      force_q <= 1'b0;
    end else begin
      if (ctl_we) begin
        nxt_q   <= mstate_e'(nxt_in);
        lrst_q  <= lrst_in;
        force_q <= force_in;
      end
      if (latch) tgt_q <= nxt_q;
      if (apply && leave_ok) cur_q <= tgt_q;
    end
  end

  assign clk_en    = (cur_q == MS_ON);
  assign rst_out_n = lrst_q && ((cur_q == MS_GATED) || (cur_q == MS_ON));
  assign ctl_q     = {force_q, 22'b0, lrst_q, 6'b0, nxt_q};
  assign stat_q    = {19'b0, clk_en, 10'b0, cur_q};
endmodule

// File: rtl/psc_domain_unit.sv
`timescale 1ns/1ps
module psc_domain_unit
  import psc_pkg::*;
#(
  parameter int   STEP_CYC    = 4,
  parameter logic ON_AT_RESET = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic on_req,
  input  logic good,
  input  logic ack,
  input  logic all_ok,
  output logic busy,
  output logic pending,
  output logic dom_on,
  output logic pwr_req,
  output logic latch,
  output logic apply
);
  localparam int CW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(STEP_CYC - 1);

  dstate_e       st;
  logic [CW-1:0] cnt;

  assign latch   = (st == DS_IDLE) && go && (dom_on || on_req);
  assign apply   = (st == DS_STEP) && (cnt == CNT_LAST);
  assign busy    = (st != DS_IDLE);
  assign pwr_req = (st == DS_PEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= DS_IDLE;
      cnt     <= '0;
      dom_on  <= ON_AT_RESET;
      pending <= 1'b0;
    end else begin
      unique case (st)
        DS_IDLE: begin
          if (latch) begin
            cnt <= '0;
            if (dom_on) begin
              st <= DS_STEP;
            end else begin
              st      <= DS_PEND;
              pending <= 1'b1;
            end
          end
        end
        DS_PEND: begin
          if (good && ack) begin
            dom_on  <= 1'b1;
            pending <= 1'b0;
            cnt     <= '0;
            st      <= DS_STEP;
          end
        end
        DS_STEP: begin
          if (apply) begin
            cnt <= '0;
            if (all_ok) st <= DS_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= DS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwr_sleep_ctrl.sv
`timescale 1ns/1ps
module pwr_sleep_ctrl
  import psc_pkg::*;
#(
  parameter int                 NUM_DOM  = 2,
  parameter int                 NUM_MOD  = 4,
  parameter int                 STEP_CYC = 4,
  parameter logic [NUM_MOD*4-1:0] MOD_DOM = 16'h1100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [11:0]        reg_addr,
  input  logic               reg_wen,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_MOD-1:0] mod_idle,
  output logic [NUM_MOD-1:0] mod_clk_en,
  output logic [NUM_MOD-1:0] mod_rst_n,
  input  logic [NUM_DOM-1:0] pwr_ack,
  output logic [NUM_DOM-1:0] pwr_req
);
  localparam int CURW = 2 * NUM_MOD;

  logic [NUM_DOM-1:0] dom_busy, dom_pend, dom_on, dom_latch, dom_apply, dom_all_ok;
  logic [NUM_DOM-1:0] dom_onreq, dom_good, dom_go;
  logic [NUM_MOD-1:0] mod_ok;
  logic [31:0]        mod_ctl  [NUM_MOD];
  logic [31:0]        mod_stat [NUM_MOD];
  logic [CURW-1:0]    cur_flat;
  logic               wdata_unused;

  assign wdata_unused = ^reg_wdata[30:9];

  // domains and their request registers
  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    logic ctl_we;
    assign ctl_we    = reg_wen && (reg_addr == A_DCTL + 12'(4 * d));
    assign dom_go[d] = reg_wen && (reg_addr == A_GO) && reg_wdata[d];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dom_onreq[d] <= 1'b0;
        dom_good[d]  <= 1'b0;
      end else if (ctl_we) begin
        dom_onreq[d] <= reg_wdata[B_ONREQ];
        dom_good[d]  <= reg_wdata[B_GOOD];
      end
    end

    psc_domain_unit #(
      .STEP_CYC    (STEP_CYC),
      .ON_AT_RESET (d == 0)
    ) u_dom (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (dom_go[d]),
      .on_req  (dom_onreq[d]),
      .good    (dom_good[d]),
      .ack     (pwr_ack[d]),
      .all_ok  (dom_all_ok[d]),
      .busy    (dom_busy[d]),
      .pending (dom_pend[d]),
      .dom_on  (dom_on[d]),
      .pwr_req (pwr_req[d]),
      .latch   (dom_latch[d]),
      .apply   (dom_apply[d])
    );
  end

  // modules, each tied to the domain chosen by MOD_DOM
  for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
    localparam int D = int'(MOD_DOM[m*4 +: 4]);
    logic    ctl_we;
    mstate_e cur;
    assign ctl_we = reg_wen && (reg_addr == A_MCTL + 12'(4 * m));

    psc_module_unit u_mod (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (ctl_we),
      .nxt_in    (reg_wdata[1:0]),
      .lrst_in   (reg_wdata[B_LRST]),
      .force_in  (reg_wdata[B_FORCE]),
      .latch     (dom_latch[D]),
      .apply     (dom_apply[D]),
      .idle_ok   (mod_idle[m]),
      .ctl_q     (mod_ctl[m]),
      .stat_q    (mod_stat[m]),
      .cur_q     (cur),
      .ok_next   (mod_ok[m]),
      .clk_en    (mod_clk_en[m]),
      .rst_out_n (mod_rst_n[m])
    );
    assign cur_flat[2*m +: 2] = cur;
  end

  always_comb begin
    for (int d = 0; d < NUM_DOM; d++) begin
      dom_all_ok[d] = 1'b1;
      for (int m = 0; m < NUM_MOD; m++) begin
        if ((int'(MOD_DOM[m*4 +: 4]) == d) && !mod_ok[m]) dom_all_ok[d] = 1'b0;
      end
    end
  end

  // register read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_PEND) reg_rdata[NUM_DOM-1:0] = dom_pend;
    if (reg_addr == A_BUSY) reg_rdata[NUM_DOM-1:0] = dom_busy;
    for (int d = 0; d < NUM_DOM; d++) begin
      if (reg_addr == A_DSTAT + 12'(4 * d)) reg_rdata[0] = dom_on[d];
      if (reg_addr == A_DCTL + 12'(4 * d)) begin
        reg_rdata[B_ONREQ] = dom_onreq[d];
        reg_rdata[B_GOOD]  = dom_good[d];
      end
    end
    for (int m = 0; m < NUM_MOD; m++) begin
      if (reg_addr == A_MSTAT + 12'(4 * m)) reg_rdata = mod_stat[m];
      if (reg_addr == A_MCTL + 12'(4 * m))  reg_rdata = mod_ctl[m];
    end
  end
endmodule

// File: rtl/psc_chk.sv
`timescale 1ns/1ps
module psc_chk #(
  parameter int                   NUM_DOM = 2,
  parameter int                   NUM_MOD = 4,
  parameter logic [NUM_MOD*4-1:0] MOD_DOM = 16'h1100
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2*NUM_MOD-1:0] cur_flat,
  input logic [NUM_DOM-1:0]   busy,
  input logic [NUM_DOM-1:0]   dom_on,
  input logic [NUM_DOM-1:0]   pending,
  input logic [NUM_DOM-1:0]   good,
  input logic [NUM_DOM-1:0]   pwr_ack,
  input logic [NUM_DOM-1:0]   pwr_req,
  input logic [NUM_MOD-1:0]   mod_rst_n
);
  for (genvar m = 0; m < NUM_MOD; m++) begin : g_m
    localparam int D = int'(MOD_DOM[m*4 +: 4]);

    p_move_when_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur_flat[2*m +: 2]) |-> $past(busy[D]));

    p_frozen_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur_flat[2*m +: 2]) |-> $past(dom_on[D]));

    p_reset_states_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_flat[2*m +: 2] < 2'd2) |-> !mod_rst_n[m]);
  end

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_d
    p_req_means_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_req[d] |-> pending[d]);

    p_pending_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pending[d]) |-> $past(good[d] && pwr_ack[d]));

    p_stays_on_r11: assert property (@(posedge clk) disable iff (!rst_n)
      dom_on[d] |=> dom_on[d]);
  end
endmodule

bind pwr_sleep_ctrl psc_chk #(
  .NUM_DOM (NUM_DOM),
  .NUM_MOD (NUM_MOD),
  .MOD_DOM (MOD_DOM)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cur_flat  (cur_flat),
  .busy      (dom_busy),
  .dom_on    (dom_on),
  .pending   (dom_pend),
  .good      (dom_good),
  .pwr_ack   (pwr_ack),
  .pwr_req   (pwr_req),
  .mod_rst_n (mod_rst_n)
);

// File: tb/pwr_sleep_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_sleep_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_wen = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  mod_idle = '0;
  logic [3:0]  mod_clk_en, mod_rst_n;
  logic [1:0]  pwr_ack = '0;
  logic [1:0]  pwr_req;

  typedef struct {
    int          kind;   // 0 register, 1 clk_en, 2 rst_n, 3 pwr_req
    logic [11:0] addr;
    logic [31:0] exp;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   total = 0;
  int   bad = 0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  pwr_sleep_ctrl u_pwr_sleep_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wen    (reg_wen),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .mod_idle   (mod_idle),
    .mod_clk_en (mod_clk_en),
    .mod_rst_n  (mod_rst_n),
    .pwr_ack    (pwr_ack),
    .pwr_req    (pwr_req)
  );

  // monitor: pops one expected item per falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t        e;
      logic [31:0] act;
      e = sb_q.pop_front();
      case (e.kind)
        1:       act = 32'(mod_clk_en);
        2:       act = 32'(mod_rst_n);
        3:       act = 32'(pwr_req);
        default: act = reg_rdata;
      endcase
      total++;
      if (act !== e.exp) begin
        bad++;
        $display("FAIL %s kind=%0d addr=%h actual=%h expected=%h", e.tag, e.kind, e.addr, act, e.exp);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(posedge clk); #1;
    reg_wen = 1'b0;
  endtask

  task automatic chk(input int kind, input logic [11:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    @(posedge clk); #1;
    reg_addr = a;
    it.kind = kind; it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic wait_idle(input int d, input string tag);
    bit seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #1;
      reg_addr = 12'h128;
      @(negedge clk);
      if (!reg_rdata[d]) begin seen = 1; break; end
    end
    total++;
    if (!seen) begin
      bad++;
      $display("FAIL %s busy never cleared actual=1 expected=0", tag);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk(0, 12'h200, 32'h1, "R1 dom0 on");
    chk(0, 12'h204, 32'h0, "R1 dom1 off");
    for (int m = 0; m < 4; m++) chk(0, 12'h800 + 12'(4*m), 32'h0, "R1 module state");
    chk(1, 12'h000, 32'h0, "R1 clk_en");
    chk(2, 12'h000, 32'h0, "R1 rst_n");
    chk(0, 12'h128, 32'h0, "R1 busy");
    chk(0, 12'h070, 32'h0, "R1 pending");
    chk(0, 12'hA00, 32'h100, "R1 ctl reset value");

    // R2 field readback
    wr(12'hA00, 32'h8000_013F);
    chk(0, 12'hA00, 32'h8000_0103, "R2 fields");
    wr(12'hA00, 32'h0000_0103);
    wr(12'hA04, 32'h0000_0102);
    chk(0, 12'hA04, 32'h102, "R2 readback");

    // R3 exact step timing on domain 0
    wr(12'h120, 32'h1);
    chk(0, 12'h128, 32'h1, "R3 busy edge1");
    chk(0, 12'h800, 32'h0, "R3 state held edge2");
    chk(0, 12'h128, 32'h1, "R3 busy edge3");
    chk(0, 12'h128, 32'h0, "R3 busy drop edge4");
    chk(0, 12'h800, 32'h1003, "R4 enabled with clock bit");
    chk(0, 12'h804, 32'h2, "R4 gated no clock bit");
    chk(1, 12'h000, 32'h1, "R4 clk_en");
    chk(2, 12'h000, 32'h3, "R5 rst_n");

    // R5 local reset bit
    wr(12'hA00, 32'h0000_0003);
    chk(2, 12'h000, 32'h2, "R5 local reset asserted");
    wr(12'hA00, 32'h0000_0103);
    chk(2, 12'h000, 32'h3, "R5 local reset released");

    // R6 and R7: leave enabled needs idle; busy go ignored
    mod_idle = 4'b0000;
    wr(12'hA00, 32'h0000_0102);
    wr(12'h120, 32'h1);
    wr(12'hA00, 32'h0000_0100);
    wr(12'h120, 32'h1);
    repeat (20) @(posedge clk);
    chk(0, 12'h128, 32'h1, "R6 still busy without idle");
    chk(0, 12'h800, 32'h1003, "R6 held enabled");
    mod_idle = 4'b0001;
    wait_idle(0, "R6 idle release");
    chk(0, 12'h800, 32'h2, "R7 captured target kept");
    mod_idle = 4'b0000;

    // R6 force bit
    wr(12'hA04, 32'h0000_0103);
    wr(12'h120, 32'h1);
    wait_idle(0, "R6 enable m1");
    chk(0, 12'h804, 32'h1003, "R4 m1 enabled");
    chk(0, 12'h800, 32'h0, "R3 m0 to off");
    chk(1, 12'h000, 32'h2, "R4 clk_en m1");
    chk(2, 12'h000, 32'h2, "R5 rst_n m1 only");
    wr(12'hA04, 32'h8000_0102);
    wr(12'h120, 32'h1);
    wait_idle(0, "R6 force");
    chk(0, 12'h804, 32'h2, "R6 forced leave");

    // R9 and R10: off domain without request, and isolation
    wr(12'hA08, 32'h0000_0103);
    wr(12'h120, 32'h1);
    wait_idle(0, "R10 d0 go");
    chk(0, 12'h808, 32'h0, "R10 d1 module untouched by d0 go");
    wr(12'h120, 32'h2);
    chk(0, 12'h128, 32'h0, "R9 go ignored");
    chk(0, 12'h070, 32'h0, "R9 no pending");
    chk(0, 12'h808, 32'h0, "R9 module unchanged");

    // R8 power-up handshake
    wr(12'h304, 32'h1);
    wr(12'h120, 32'h2);
    chk(0, 12'h070, 32'h2, "R8 pending set");
    chk(3, 12'h000, 32'h2, "R8 pwr_req");
    chk(0, 12'h204, 32'h0, "R11 still off");
    chk(0, 12'h128, 32'h2, "R8 busy");
    wr(12'h304, 32'h101);
    repeat (10) @(posedge clk);
    chk(0, 12'h070, 32'h2, "R8 good without ack waits");
    chk(0, 12'h808, 32'h0, "R8 modules wait");
    pwr_ack = 2'b10;
    wait_idle(1, "R8 completes");
    chk(0, 12'h070, 32'h0, "R8 pending cleared");
    chk(0, 12'h204, 32'h1, "R11 domain on");
    chk(0, 12'h808, 32'h1003, "R8 module stepped");
    chk(3, 12'h000, 32'h0, "R8 request dropped");
    chk(0, 12'h804, 32'h2, "R10 d0 module untouched by d1 go");
    chk(0, 12'h304, 32'h101, "R11 control readback");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule